// File: doc/BRIEF.md
# Mode-Gated SCSI Command Register

This block is the command-register front end of a SCSI protocol controller. The host writes command bytes to it. For each byte the block records the value, takes the command group from the byte, and checks that group against the controller's current connection state. That state is disconnected, initiator or target. A command that is allowed in the current state is handed to the downstream sequencer as a one-cycle dispatch strobe, together with its 7-bit code. The byte's top bit is also taken as the sticky DMA-mode flag. A command that is not allowed never reaches the sequencer. Instead it latches the illegal-command bit in the interrupt status and raises the interrupt line.

The connection state moves on bus-side events that arrive as single-cycle inputs: the outcome of a selection, being selected as a target, an unsupported-LUN abort, and a SCSI bus reset. It also moves when an accepted message-accept command completes. The interrupt status bits stay latched until the host reads the status register. That read clears them.

The state machine has three states:
- DISC (code 0). Entered on reset, on a bus reset, on an abort, on an accepted message-accept, and on a selection with no device present.
- INIT (code 1). Entered from DISC on a selection with a device present.
- TARG (code 2). Entered from DISC on a target-select event.

Top module: `scsi_cmd_gate`

## Requirements
- R1: After reset the register, dispatch strobe, DMA flag and status are all 0, the IRQ is low and the state is DISC (`conn_mode` = 0).
- R2: Every write stores the full byte in `cmd_q` on the next cycle, whether the command is legal or not.
- R3: A command whose group field (bits 6:4) is 0 is legal in every state.
- R4: In DISC only group 4 is legal besides group 0. In INIT only group 1 is legal besides group 0. Groups 2, 3, 5, 6 and 7 are never legal.
- R5: In TARG every command outside group 0 is illegal.
- R6: A legal write produces `disp_stb` high for exactly the following cycle, with `disp_code` equal to bits 6:0. `dma_mode` takes bit 7.
- R7: An illegal write gives no strobe and leaves `dma_mode` unchanged. It sets status bit 6 (0x40) and raises `irq`.
- R8: In DISC, a selection with a device present moves the state to INIT. A selection with no device present stays in DISC and sets status bit 5 (0x20). Selection events outside DISC are ignored.
- R9: An accepted message-accept (code 0x12) or an abort input returns the state to DISC and sets status bit 5 (0x20).
- R10: `irq` is high exactly while any status bit is latched. A status read clears the bits, but a bit set in the same cycle as the read survives it.
- R11: In DISC a target-select event moves the state to TARG.
- R12: A bus reset event forces DISC and sets status bit 7 (0x80). It takes priority over every other event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Host write strobe for the command register |
| cmd_wdata | input | 8 | Written command byte (bit 7 = DMA, bits 6:0 = code) |
| isr_rd | input | 1 | Host read of the interrupt status; clears latched bits |
| sel_done | input | 1 | Selection attempt finished this cycle |
| sel_present | input | 1 | Qualifies `sel_done`: the addressed device answered |
| tgt_sel | input | 1 | Controller was selected as a target |
| lun_abort | input | 1 | Unsupported-LUN abort; drops the connection |
| bus_rst | input | 1 | SCSI bus reset seen |
| cmd_q | output | 8 | Last written command byte |
| disp_stb | output | 1 | One-cycle dispatch strobe for a legal command |
| disp_code | output | 7 | Code of the dispatched command |
| dma_mode | output | 1 | DMA flag of the last legal command |
| conn_mode | output | 2 | Connection state (0 DISC, 1 INIT, 2 TARG) |
| isr_q | output | 8 | Latched interrupt status |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the group edges: groups 3, 5, 6 and 7 must be rejected even though only 0, 1, 2 and 4 have names. A decoder that checks a single bit of the group field would accept them. It writes the DMA bit on rejected commands, which would flip `dma_mode` in a design that latches the flag before the legality check. It also collides a status read with a new illegal write, where a clear-wins latch loses the interrupt. Finally it fires selection events while connected, which a design that listens in every state would act on by dropping an established initiator link.

// File: rtl/scsi_cmd_pkg.sv
package scsi_cmd_pkg;

    typedef enum logic [1:0] {
        MODE_DISC = 2'd0,
        MODE_INIT = 2'd1,
        MODE_TARG = 2'd2
    } conn_mode_e;

    localparam int CMD_W     = 8;
    localparam int CODE_W    = CMD_W - 1;
    localparam int GRP_LSB   = 4;
    localparam int GRP_W     = 3;

    localparam logic [GRP_W-1:0] GRP_MISC = 3'd0;
    localparam logic [GRP_W-1:0] GRP_INIT = 3'd1;
    localparam logic [GRP_W-1:0] GRP_TARG = 3'd2;
    localparam logic [GRP_W-1:0] GRP_DISC = 3'd4;

    localparam int ISR_W     = 8;
    localparam int ISR_DC    = 5;
    localparam int ISR_IL    = 6;
    localparam int ISR_RST   = 7;

endpackage

// File: rtl/scsi_cmd_classify.sv
module scsi_cmd_classify
    import scsi_cmd_pkg::*;
#(
    parameter logic [CODE_W-1:0] MSGACC_CODE = 7'h12
) (
    input  logic [CODE_W-1:0] code,
    input  conn_mode_e        mode,
    output logic              legal,
    output logic              is_msgacc
);
    logic [GRP_W-1:0] grp;

    assign grp = code[GRP_LSB +: GRP_W];

    always_comb begin
        legal = 1'b0;
        if (grp == GRP_MISC) begin
            legal = 1'b1;
        end else begin
            unique case (mode)
                MODE_DISC: legal = (grp == GRP_DISC);
                MODE_INIT: legal = (grp == GRP_INIT);
                MODE_TARG: legal = 1'b0;
                default:   legal = 1'b0;
            endcase
        end
    end

    assign is_msgacc = (code == MSGACC_CODE);

endmodule

// File: rtl/scsi_conn_fsm.sv
module scsi_conn_fsm
    import scsi_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_rst,
    input  logic       msgacc_ok,
    input  logic       lun_abort,
    input  logic       sel_done,
    input  logic       sel_present,
    input  logic       tgt_sel,
    output conn_mode_e mode,
    output logic       dc_set
);
    conn_mode_e state_q;
    conn_mode_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_DISC;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        dc_set  = 1'b0;
        if (bus_rst) begin
            state_d = MODE_DISC;
        end else if (msgacc_ok || lun_abort) begin
            state_d = MODE_DISC;
            dc_set  = 1'b1;
        end else begin
            unique case (state_q)
                MODE_DISC: begin
                    if (sel_done) begin
                        if (sel_present) state_d = MODE_INIT;
                        else             dc_set  = 1'b1;
                    end else if (tgt_sel) begin
                        state_d = MODE_TARG;
                    end
                end
                MODE_INIT: state_d = MODE_INIT;
                MODE_TARG: state_d = MODE_TARG;
                default:   state_d = MODE_DISC;
            endcase
        end
    end

    assign mode = state_q;

endmodule

// File: rtl/scsi_isr_latch.sv
module scsi_isr_latch
    import scsi_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ISR_W-1:0] set_bits,
    input  logic             rd_clr,
    output logic [ISR_W-1:0] isr
);
    logic [ISR_W-1:0] isr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (rd_clr ? '0 : isr_q) | set_bits;
    end

    assign isr = isr_q;

endmodule

// File: rtl/scsi_cmd_gate.sv
module scsi_cmd_gate
    import scsi_cmd_pkg::*;
#(
    parameter logic [CODE_W-1:0] MSGACC_CODE = 7'h12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_wdata,
    input  logic              isr_rd,
    input  logic              sel_done,
    input  logic              sel_present,
    input  logic              tgt_sel,
    input  logic              lun_abort,
    input  logic              bus_rst,
    output logic [CMD_W-1:0]  cmd_q,
    output logic              disp_stb,
    output logic [CODE_W-1:0] disp_code,
    output logic              dma_mode,
    output logic [1:0]        conn_mode,
    output logic [ISR_W-1:0]  isr_q,
    output logic              irq
);
    conn_mode_e       mode;
    logic             legal;
    logic             is_msgacc;
    logic             accept;
    logic             reject;
    logic             dc_set;
    logic [ISR_W-1:0] set_bits;

    scsi_cmd_classify #(.MSGACC_CODE(MSGACC_CODE)) u_class (
        .code      (cmd_wdata[CODE_W-1:0]),
        .mode      (mode),
        .legal     (legal),
        .is_msgacc (is_msgacc)
    );

    assign accept = cmd_wr && legal;
    assign reject = cmd_wr && !legal;

    scsi_conn_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_rst     (bus_rst),
        .msgacc_ok   (accept && is_msgacc),
        .lun_abort   (lun_abort),
        .sel_done    (sel_done),
        .sel_present (sel_present),
        .tgt_sel     (tgt_sel),
        .mode        (mode),
        .dc_set      (dc_set)
    );

    always_comb begin
        set_bits          = '0;
        set_bits[ISR_IL]  = reject;
        set_bits[ISR_DC]  = dc_set;
        set_bits[ISR_RST] = bus_rst;
    end

    scsi_isr_latch u_isr (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (set_bits),
        .rd_clr   (isr_rd),
        .isr      (isr_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            disp_stb  <= 1'b0;
            disp_code <= '0;
            dma_mode  <= 1'b0;
        end else begin
            disp_stb <= accept;
            if (cmd_wr) cmd_q <= cmd_wdata;
            if (accept) begin
                disp_code <= cmd_wdata[CODE_W-1:0];
                dma_mode  <= cmd_wdata[CMD_W-1];
            end
        end
    end

    assign conn_mode = mode;
    assign irq       = |isr_q;

endmodule

// File: rtl/scsi_cmd_gate_chk.sv
module scsi_cmd_gate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wr,
    input logic [7:0] cmd_wdata,
    input logic       isr_rd,
    input logic       disp_stb,
    input logic       dma_mode,
    input logic [1:0] conn_mode,
    input logic [7:0] isr_q,
    input logic       irq
);
    assert_mode_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        conn_mode != 2'd3);

    assert_stb_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        disp_stb |-> $past(cmd_wr));

    assert_illegal_no_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isr_q[6]) |-> !disp_stb);

    assert_dma_on_dispatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode != $past(dma_mode)) |-> disp_stb);

    assert_target_rejects_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && conn_mode == 2'd2 && cmd_wdata[6:4] != 3'd0) |=> !disp_stb);

    assert_irq_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(isr_rd));

endmodule

bind scsi_cmd_gate scsi_cmd_gate_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_wdata (cmd_wdata),
    .isr_rd    (isr_rd),
    .disp_stb  (disp_stb),
    .dma_mode  (dma_mode),
    .conn_mode (conn_mode),
    .isr_q     (isr_q),
    .irq       (irq)
);

// File: tb/test_scsi_cmd_gate.sv
`timescale 1ns/1ps
module test_scsi_cmd_gate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 0, isr_rd = 0, sel_done = 0, sel_present = 0;
    logic       tgt_sel = 0, lun_abort = 0, bus_rst = 0;
    logic [7:0] cmd_wdata = 0;
    logic [7:0] cmd_q;
    logic       disp_stb;
    logic [6:0] disp_code;
    logic       dma_mode;
    logic [1:0] conn_mode;
    logic [7:0] isr_q;
    logic       irq;

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";

    // reference model state
    int m_mode = 0, m_isr = 0, m_cmd = 0, m_code = 0, m_dma = 0, m_stb = 0;

    always #4 clk = ~clk;

    scsi_cmd_gate i_scsi_cmd_gate (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .isr_rd(isr_rd), .sel_done(sel_done), .sel_present(sel_present),
        .tgt_sel(tgt_sel), .lun_abort(lun_abort), .bus_rst(bus_rst),
        .cmd_q(cmd_q), .disp_stb(disp_stb), .disp_code(disp_code),
        .dma_mode(dma_mode), .conn_mode(conn_mode), .isr_q(isr_q), .irq(irq));

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_isr = 0; m_cmd = 0; m_code = 0; m_dma = 0; m_stb = 0;
        end else begin
            int grp, set, lg, code;
            bit macc;
            set  = 0;
            code = cmd_wdata & 8'h7f;
            grp  = (cmd_wdata >> 4) & 7;
            lg   = (grp == 0) || (m_mode == 0 && grp == 4) || (m_mode == 1 && grp == 1);
            m_stb = 0;
            macc = 0;
            if (cmd_wr) begin
                m_cmd = cmd_wdata;
                if (lg != 0) begin
                    m_stb = 1; m_code = code; m_dma = cmd_wdata[7];
                    macc = (code == 'h12);
                end else set |= 'h40;
            end
            if (bus_rst) begin
                m_mode = 0; set |= 'h80;
            end else if (macc || lun_abort) begin
                m_mode = 0; set |= 'h20;
            end else if (m_mode == 0) begin
                if (sel_done) begin
                    if (sel_present) m_mode = 1; else set |= 'h20;
                end else if (tgt_sel) m_mode = 2;
            end
            m_isr = (isr_rd ? 0 : m_isr) | set;
        end
        #2;
        check(cur_req, "cmd_q", cmd_q, m_cmd);
        check(cur_req, "disp_stb", disp_stb, m_stb);
        if (m_stb != 0) check(cur_req, "disp_code", disp_code, m_code);
        check(cur_req, "dma_mode", dma_mode, m_dma);
        check(cur_req, "conn_mode", conn_mode, m_mode);
        check(cur_req, "isr_q", isr_q, m_isr);
        check(cur_req, "irq", irq, m_isr != 0);
    end

    task automatic drv(input logic w, input logic [7:0] d, input logic rd,
                       input logic sd, input logic sp, input logic ts,
                       input logic ab, input logic br);
        @(negedge clk);
        cmd_wr = w; cmd_wdata = d; isr_rd = rd; sel_done = sd; sel_present = sp;
        tgt_sel = ts; lun_abort = ab; bus_rst = br;
    endtask

    task automatic wr(input logic [7:0] d); drv(1, d, 0, 0, 0, 0, 0, 0); endtask
    task automatic idle(); drv(0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic rd(); drv(0, 0, 1, 0, 0, 0, 0, 0); endtask

    initial begin : watchdog
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        check("R1", "irq in reset", irq, 0);
        check("R1", "conn_mode in reset", conn_mode, 0);
        rst_n = 1'b1;
        idle(); idle();

        cur_req = "R3";  wr(8'h01); idle();
        cur_req = "R4";  wr(8'h41); wr(8'h11); wr(8'h21); wr(8'h31); wr(8'h51);
        wr(8'h61); wr(8'h71); idle(); rd(); idle();
        cur_req = "R6";  wr(8'hC2); wr(8'h42); wr(8'h03); idle();
        cur_req = "R7";  wr(8'hC2); wr(8'h91); idle();
        check("R7", "dma_mode kept after illegal", dma_mode, 1);
        check("R7", "irq after illegal", irq, 1);
        cur_req = "R2";  wr(8'hA5); idle();
        check("R2", "cmd_q illegal byte", cmd_q, 8'hA5);
        cur_req = "R10"; idle(); idle();
        drv(1, 8'h15, 1, 0, 0, 0, 0, 0); idle();
        check("R10", "IL survives read collision", isr_q, 8'h40);
        rd(); idle();
        check("R10", "irq cleared by read", irq, 0);

        cur_req = "R8";  drv(0, 0, 0, 1, 0, 0, 0, 0); idle();
        check("R8", "no device -> DC", isr_q, 8'h20);
        rd(); drv(0, 0, 0, 1, 1, 0, 0, 0); idle();
        check("R8", "present -> INIT", conn_mode, 1);
        drv(0, 0, 0, 1, 0, 0, 0, 0); drv(0, 0, 0, 0, 0, 1, 0, 0); idle();
        check("R8", "selection ignored in INIT", conn_mode, 1);
        cur_req = "R4";  wr(8'h10); wr(8'h40); wr(8'h20); wr(8'h00); rd(); idle();
        cur_req = "R9";  wr(8'h92); idle();
        check("R9", "msgacc -> DISC", conn_mode, 0);
        rd(); drv(0, 0, 0, 1, 1, 0, 0, 0); drv(0, 0, 0, 0, 0, 0, 1, 0); idle();
        check("R9", "abort -> DISC", conn_mode, 0);
        rd();
        cur_req = "R11"; drv(0, 0, 0, 0, 0, 1, 0, 0); idle();
        check("R11", "tgt_sel -> TARG", conn_mode, 2);
        cur_req = "R5";  wr(8'h20); wr(8'h10); wr(8'h40); wr(8'h12); wr(8'h02); idle();
        rd();
        cur_req = "R12"; drv(1, 8'h12, 0, 1, 1, 1, 1, 1); idle();
        check("R12", "bus reset wins", conn_mode, 0);
        rd(); idle();

        cur_req = "R6";
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom_range(0, 99);
            drv(r < 40, 8'($urandom), r > 85, r == 5 || r == 6, r == 6,
                r == 7, r == 8, r == 9);
        end
        idle(); idle();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule